// File: doc/BRIEF.md
# Clock Ratio Enable Generator

This block runs on one fast base clock and turns it into three single-cycle enable strobes: a processor-core enable, a bus enable and a peripheral enable. It creates no new clock nets. Logic elsewhere in the chip stays on the base clock and advances only in cycles where its strobe is high. The peripheral strobe is the time base for the downstream timers.

One 16-bit frequency-control register sets all three ratios. It is written through a single-cycle write strobe with a data word, and its contents are always visible on a read-back port. Three 3-bit code fields select the ratios from small lookup tables, and several of those ratios are not powers of two. A frequency-multiplier-enable bit models a bypassed multiplier: when that bit is clear, every ratio becomes six times longer. Each write restarts all three divider counters together. The new ratios therefore begin with a fresh, aligned period on the next base-clock cycle.

Top module: `crg_strobe_top`

## Requirements
- R1: After reset the register reads 0x0E0A and all three counters are at phase zero. The core ratio is then 1, the bus ratio 2 and the peripheral ratio 4, with all strobes high in the first cycle.
- R2: Register bits 8:6 select the core ratio. Codes 0 to 5 give 1, 2, 3, 4, 5 and 8. With code 0 and the multiplier enabled, the core strobe stays high in every cycle.
- R3: Register bits 5:3 select the bus ratio from the same table as the core field.
- R4: Register bits 2:0 select the peripheral ratio. Codes 0 to 4 give 2, 3, 4, 6 and 8.
- R5: Out-of-range codes divide by 8. For the core and bus fields these are codes 6 and 7. For the peripheral field they are codes 5, 6 and 7.
- R6: Bit 10 is the multiplier-enable bit. When it is 0, every ratio is the table value times 6.
- R7: A write takes effect at the next clock edge. All three strobes are high in the following cycle, and each then repeats at its new ratio with no leftover partial period.
- R8: A strobe with a ratio N greater than 1 is high for exactly one cycle out of every N.
- R9: The read-back port shows all 16 written bits, including bits that affect no ratio. It holds its value until the next write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the frequency-control register |
| cfg_wdata | input | 16 | Data to write |
| cfg_rdata | output | 16 | Current register contents |
| cpu_en | output | 1 | Processor-core enable strobe |
| bus_en | output | 1 | Bus enable strobe |
| per_en | output | 1 | Peripheral enable strobe |

## Verification
The bench builds the block with its default parameters: a 16-bit register, field positions 8:6, 5:3 and 2:0, the enable bit at 10 and a bypass multiplier of 6. With these values the longest period is 48 cycles. That makes it practical to visit every code of every field, including all out-of-range codes, and every bypassed ratio, each for several full periods. It also leaves room for writes that land in the middle of a period and for writes on consecutive cycles.

// File: rtl/crg_pkg.sv
`timescale 1ns/1ps
package crg_pkg;

    localparam int unsigned FIELD_W        = 3;
    localparam int unsigned MAX_BASE_RATIO = 8;

    typedef enum logic [0:0] {
        FLD_CORE   = 1'b0,
        FLD_PERIPH = 1'b1
    } fld_kind_e;

    // core and bus share this table; out-of-range codes fall to 8
    function automatic logic [3:0] core_ratio(input logic [FIELD_W-1:0] code);
        logic [3:0] r;
        case (code)
            3'd0:    r = 4'd1;
            3'd1:    r = 4'd2;
            3'd2:    r = 4'd3;
            3'd3:    r = 4'd4;
            3'd4:    r = 4'd5;
            default: r = 4'd8;
        endcase
        return r;
    endfunction

    function automatic logic [3:0] periph_ratio(input logic [FIELD_W-1:0] code);
        logic [3:0] r;
        case (code)
            3'd0:    r = 4'd2;
            3'd1:    r = 4'd3;
            3'd2:    r = 4'd4;
            3'd3:    r = 4'd6;
            default: r = 4'd8;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/crg_ctrl_reg.sv
`timescale 1ns/1ps
module crg_ctrl_reg #(
    parameter int unsigned     REG_W   = 16,
    parameter logic [REG_W-1:0] RST_VAL = 16'h0E0A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] ctrl_o
);

    typedef struct packed {
        logic [REG_W-1:0] val;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.val = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.val <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o = st_q.val;

endmodule

// File: rtl/crg_ratio_sel.sv
`timescale 1ns/1ps
module crg_ratio_sel #(
    parameter int unsigned          REG_W        = 16,
    parameter int unsigned          FIELD_LSB    = 0,
    parameter int unsigned          PLL_BIT      = 10,
    parameter int unsigned          PLL_OFF_MULT = 6,
    parameter int unsigned          RAT_W        = 7,
    parameter crg_pkg::fld_kind_e   KIND         = crg_pkg::FLD_CORE
) (
    input  logic [REG_W-1:0] ctrl_i,
    output logic [RAT_W-1:0] ratio_o
);

    localparam int unsigned FW = crg_pkg::FIELD_W;

    logic [FW-1:0] code;
    logic [3:0]    base;

    assign code = ctrl_i[FIELD_LSB +: FW];

    generate
        if (KIND == crg_pkg::FLD_PERIPH) begin : g_periph
            assign base = crg_pkg::periph_ratio(code);
        end else begin : g_core
            assign base = crg_pkg::core_ratio(code);
        end
    endgenerate

    always_comb begin
        if (ctrl_i[PLL_BIT]) begin
            ratio_o = RAT_W'(base);
        end else begin
            ratio_o = RAT_W'(base) * RAT_W'(PLL_OFF_MULT);
        end
    end

endmodule

// File: rtl/crg_strobe_div.sv
`timescale 1ns/1ps
module crg_strobe_div #(
    parameter int unsigned CNT_W = 6,
    parameter int unsigned RAT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload_i,
    input  logic [RAT_W-1:0] ratio_i,
    output logic             strobe_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (reload_i) begin
            st_d.cnt = '0;
        end else if (({1'b0, st_q.cnt} + RAT_W'(1)) >= ratio_i) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // phase zero of every period carries the strobe
    assign strobe_o = (st_q.cnt == '0);

endmodule

// File: rtl/crg_strobe_top.sv
`timescale 1ns/1ps
module crg_strobe_top #(
    parameter int unsigned      REG_W        = 16,
    parameter logic [REG_W-1:0] RST_VAL      = 16'h0E0A,
    parameter int unsigned      CPU_LSB      = 6,
    parameter int unsigned      BUS_LSB      = 3,
    parameter int unsigned      PER_LSB      = 0,
    parameter int unsigned      PLL_BIT      = 10,
    parameter int unsigned      PLL_OFF_MULT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    output logic             cpu_en,
    output logic             bus_en,
    output logic             per_en
);

    localparam int unsigned NCH       = 3;
    localparam int unsigned MAX_RATIO = crg_pkg::MAX_BASE_RATIO * PLL_OFF_MULT;
    localparam int unsigned CNT_W     = $clog2(MAX_RATIO);
    localparam int unsigned RAT_W     = CNT_W + 1;

    logic [REG_W-1:0] ctrl;
    logic [NCH-1:0]   strobe;

    crg_ctrl_reg #(
        .REG_W   (REG_W),
        .RST_VAL (RST_VAL)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cfg_wr),
        .wdata_i (cfg_wdata),
        .ctrl_o  (ctrl)
    );

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            localparam int unsigned LSB = (g == 0) ? CPU_LSB :
                                          (g == 1) ? BUS_LSB : PER_LSB;
            localparam crg_pkg::fld_kind_e KIND =
                (g == 2) ? crg_pkg::FLD_PERIPH : crg_pkg::FLD_CORE;

            logic [RAT_W-1:0] ratio;

            crg_ratio_sel #(
                .REG_W        (REG_W),
                .FIELD_LSB    (LSB),
                .PLL_BIT      (PLL_BIT),
                .PLL_OFF_MULT (PLL_OFF_MULT),
                .RAT_W        (RAT_W),
                .KIND         (KIND)
            ) u_sel (
                .ctrl_i  (ctrl),
                .ratio_o (ratio)
            );

            crg_strobe_div #(
                .CNT_W (CNT_W),
                .RAT_W (RAT_W)
            ) u_div (
                .clk      (clk),
                .rst_n    (rst_n),
                .reload_i (cfg_wr),
                .ratio_i  (ratio),
                .strobe_o (strobe[g])
            );
        end
    endgenerate

    assign cfg_rdata = ctrl;
    assign cpu_en    = strobe[0];
    assign bus_en    = strobe[1];
    assign per_en    = strobe[2];

endmodule

// File: rtl/crg_checker.sv
`timescale 1ns/1ps
module crg_checker #(
    parameter int unsigned      REG_W   = 16,
    parameter logic [REG_W-1:0] RST_VAL = 16'h0E0A,
    parameter int unsigned      CPU_LSB = 6,
    parameter int unsigned      BUS_LSB = 3,
    parameter int unsigned      PLL_BIT = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic [REG_W-1:0] cfg_wdata,
    input logic [REG_W-1:0] cfg_rdata,
    input logic             cpu_en,
    input logic             bus_en,
    input logic             per_en
);

    assert_reset_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (cfg_rdata == RST_VAL));

    assert_cpu_unity_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[CPU_LSB +: 3] == 3'd0 && cfg_rdata[PLL_BIT]) |-> cpu_en);

    assert_bus_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !cfg_wr && (cfg_rdata[BUS_LSB +: 3] != 3'd0 || !cfg_rdata[PLL_BIT]))
        |=> !bus_en);

    assert_bypass_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_en && !cfg_wr && !cfg_rdata[PLL_BIT]) |=> !cpu_en);

    assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_wr)) |-> (cpu_en && bus_en && per_en));

    assert_per_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (per_en && !cfg_wr) |=> !per_en);

    assert_readback_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_wr)) |-> (cfg_rdata == $past(cfg_wdata)));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg_wr)) |-> $stable(cfg_rdata));

endmodule

bind crg_strobe_top crg_checker #(
    .REG_W   (REG_W),
    .RST_VAL (RST_VAL),
    .CPU_LSB (CPU_LSB),
    .BUS_LSB (BUS_LSB),
    .PLL_BIT (PLL_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .cpu_en    (cpu_en),
    .bus_en    (bus_en),
    .per_en    (per_en)
);

// File: tb/sim_crg_strobe_top.sv
`timescale 1ns/1ps
module sim_crg_strobe_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = 16'h0000;
    logic [15:0] cfg_rdata;
    logic        cpu_en, bus_en, per_en;

    always #2.5 clk = ~clk;

    crg_strobe_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cpu_en    (cpu_en),
        .bus_en    (bus_en),
        .per_en    (per_en)
    );

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    check_on = 1'b0;
    bit    finished = 1'b0;
    string tag = "R1";

    // reference model
    int core_tab [8] = '{1, 2, 3, 4, 5, 8, 8, 8};
    int per_tab  [8] = '{2, 3, 4, 6, 8, 8, 8, 8};
    int m_ctrl = 16'h0E0A;
    int m_phase [3] = '{0, 0, 0};

    function automatic int model_ratio(int ch, int ctrl);
        int shift = (ch == 0) ? 6 : (ch == 1) ? 3 : 0;
        int code  = (ctrl >> shift) & 7;
        int r     = (ch == 2) ? per_tab[code] : core_tab[code];
        if (((ctrl >> 10) & 1) == 0) r = r * 6;
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl = 16'h0E0A;
            for (int c = 0; c < 3; c++) m_phase[c] = 0;
        end else if (cfg_wr) begin
            m_ctrl = int'(cfg_wdata);
            for (int c = 0; c < 3; c++) m_phase[c] = 0;
        end else begin
            for (int c = 0; c < 3; c++) begin
                if (m_phase[c] + 1 >= model_ratio(c, m_ctrl)) m_phase[c] = 0;
                else m_phase[c] = m_phase[c] + 1;
            end
        end
    end

    task automatic compare();
        logic [18:0] act, exp;
        act = {cfg_rdata, cpu_en, bus_en, per_en};
        exp = {m_ctrl[15:0], m_phase[0] == 0, m_phase[1] == 0, m_phase[2] == 0};
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s t=%0t rdata/cpu/bus/per actual=%h/%b/%b/%b expected=%h/%b/%b/%b",
                     tag, $time, act[18:3], act[2], act[1], act[0],
                     exp[18:3], exp[2], exp[1], exp[0]);
        end
    endtask

    always @(negedge clk) begin
        if (check_on) compare();
    end

    task automatic wr(input logic [15:0] d);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        summary();
    end

    initial begin
        // R1: reset state, sampled while reset is still applied
        idle(3);
        tag = "R1";
        compare();
        @(posedge clk);
        #1 rst_n = 1'b1;
        check_on = 1'b1;
        idle(40);

        // R2 / R5: core field, all codes
        for (int k = 0; k < 8; k++) begin
            tag = (k >= 6) ? "R5" : "R2";
            wr(16'h0400 | 16'(k << 6) | 16'h0008 | 16'h0002);
            idle(60);
        end
        // R3 / R5: bus field, all codes
        for (int k = 0; k < 8; k++) begin
            tag = (k >= 6) ? "R5" : "R3";
            wr(16'h0400 | 16'(k << 3) | 16'h0001);
            idle(60);
        end
        // R4 / R5: peripheral field, all codes
        for (int k = 0; k < 8; k++) begin
            tag = (k >= 5) ? "R5" : "R4";
            wr(16'h0440 | 16'(k));
            idle(60);
        end

        // R6: multiplier bypassed
        tag = "R6";
        wr(16'h0000);
        idle(100);
        wr(16'h009B);
        idle(160);
        wr(16'h01FF);
        idle(200);

        // R7: writes mid-period and back to back
        tag = "R7";
        wr(16'h0E0A);
        idle(3);
        wr(16'h0412);
        idle(2);
        wr(16'h0412);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = 16'h0489;
        @(negedge clk);
        cfg_wdata = 16'h04D3;
        @(negedge clk);
        cfg_wr = 1'b0;
        idle(50);

        // R8: default ratios, core held high, others pulsed once per period
        tag = "R8";
        wr(16'h0E0A);
        idle(30);

        // R9: unused bits read back and hold
        tag = "R9";
        wr(16'hF5A3);
        idle(100);
        wr(16'h2A00);
        idle(120);

        check_on = 1'b0;
        summary();
    end

endmodule